// File: doc/BRIEF.md
# Synchronous-Capable Serial Transmitter with Break

This block shifts out one character at a time on a single serial data line. A character offered on a valid/ready input is framed as one low start bit, the data bits least significant first, and a high stop period whose length is chosen per frame from half a bit up to two bits. All timing is counted in oversample ticks, sixteen to a bit by default, delivered on a one-cycle strobe from an external baud generator. The block has no internal rate divider.

For synchronous links the block can also drive a bit clock. When the clock is enabled, each data bit gets exactly one clock period, with its edges placed at the start and at the middle of the bit. A polarity input sets the level the clock rests at. A phase input chooses whether the first or the second transition of each period is the capture edge. When the clock is disabled the line holds its rest level. When the bus-break mode is enabled, a break request drives the data line low for thirteen bit times, followed by one high bit. Every configuration input is captured when a character or break is accepted, so changes made during a frame apply only to the next frame.

Top module: `sync_serial_tx`

## Requirements
- R1: In reset and whenever `busy` is low, `tx_line` is 1, `in_ready` is 1 (unless a break is requested with break mode enabled), and `clk_line` equals `cfg_cpol`.
- R2: A byte taken with `in_valid && in_ready` raises `busy` and drives `tx_line` low from the next cycle. The start bit lasts 16 ticks, followed by the 8 data bits, bit 0 first, each lasting 16 ticks.
- R3: The stop period is high, and its length is set by `cfg_stop`: 2'b00 gives 16 ticks, 2'b01 gives 8 ticks, 2'b11 gives 24 ticks and 2'b10 gives 32 ticks. `busy` falls on the clock edge that takes the last stop tick.
- R4: With `cfg_clk_en`=0 at acceptance, `clk_line` stays at the polarity level for the whole frame.
- R5: With `cfg_clk_en`=1 at acceptance, `clk_line` rests at `cfg_cpol` during the start and stop bits. During ticks 0-7 of each data bit it is the rest level when `cfg_cpha`=0 and the inverted level when `cfg_cpha`=1. Ticks 8-15 take the opposite level.
- R6: With `cfg_lin_en`=1 and `busy` low, `brk_req` starts a break: `tx_line` is low for 208 ticks, then high for 16 ticks, with `busy` high throughout. A break request takes priority over a byte offered in the same cycle, and that byte is not consumed.
- R7: With `cfg_lin_en`=0, `brk_req` has no effect: `tx_line` stays high and `busy` stays low.
- R8: Changes to `cfg_stop`, `cfg_clk_en`, `cfg_cpha` or `cfg_cpol` made while `busy` is high do not alter the frame in progress.
- R9: The block advances only on cycles with `baud_tick` high. With one tick every third cycle, a frame with a half stop bit keeps `busy` high for 152 ticks (454 to 456 cycles).
- R10: `in_ready` is low while `busy` is high, and a byte offered then is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversample strobe, 16 per bit |
| cfg_stop | input | 2 | Stop period select |
| cfg_clk_en | input | 1 | Enables bit clock pulses |
| cfg_cpol | input | 1 | Rest level of the bit clock |
| cfg_cpha | input | 1 | 1: second clock transition is the capture edge |
| cfg_lin_en | input | 1 | Enables break requests |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| brk_req | input | 1 | Request to send a break |
| tx_line | output | 1 | Serial data line, idles high |
| clk_line | output | 1 | Bit clock line |
| busy | output | 1 | Frame or break in progress |

## Verification
The hardest situation to reach from the ports is a frame whose configuration inputs change partway through. From outside, the only sign that the sampled settings are held is that the output does not change. The bench accepts a frame and, five cycles later, flips the stop length, clock enable and phase inputs. It then compares every cycle of the data and clock lines against the settings captured at acceptance. A break request that arrives in the same cycle as a valid byte is also driven deliberately, and the low span that follows shows that the byte was left untaken.

// File: rtl/sst_pkg.sv
package sst_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_STOP,
      PH_BREAK,
      PH_BRK_STOP
   } phase_e;

   // encoding decoded by the sequencer, fixed by the control field
   typedef enum logic [1:0] {
      STOP_ONE      = 2'b00,
      STOP_HALF     = 2'b01,
      STOP_TWO      = 2'b10,
      STOP_ONE_HALF = 2'b11
   } stop_e;

   typedef struct packed {
      stop_e stop;
      logic  clk_en;
      logic  cpol;
      logic  cpha;
   } frame_cfg_t;

endpackage

// File: rtl/sst_frame_store.sv
module sst_frame_store
   import sst_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  frame_cfg_t        cfg_in,
   input  logic [DATA_W-1:0] data_in,
   output frame_cfg_t        cfg_q,
   output logic              bit_q
);

   logic [DATA_W-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_q <= frame_cfg_t'('0);
      else if (load)
         cfg_q <= cfg_in;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      logic next_in;
      if (i == DATA_W - 1) begin : g_top
         assign next_in = 1'b1;
      end else begin : g_mid
         assign next_in = sr[i+1];
      end
      always_ff @(posedge clk) begin
         if (!rst_n)
            sr[i] <= 1'b1;
         else if (load)
            sr[i] <= data_in[i];
         else if (shift)
            sr[i] <= next_in;
      end
   end

   assign bit_q = sr[0];

endmodule

// File: rtl/sst_sequencer.sv
module sst_sequencer
   import sst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVS      = 16,
   parameter int BRK_BITS = 13,
   localparam int TW      = $clog2(BRK_BITS * OVS),
   localparam int BW      = $clog2(DATA_W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          start_data,
   input  logic          start_break,
   input  stop_e         stop_sel,
   output phase_e        phase,
   output logic [TW-1:0] tcnt,
   output logic          shift,
   output logic          busy
);

   localparam logic [TW-1:0] BIT_T   = TW'(OVS);
   localparam logic [TW-1:0] HALF_T  = TW'(OVS / 2);
   localparam logic [TW-1:0] BRK_T   = TW'(BRK_BITS * OVS);
   localparam logic [BW-1:0] LAST_IX = BW'(DATA_W - 1);

   logic [TW-1:0] stop_len;
   logic [TW-1:0] len;
   logic [BW-1:0] bidx;
   logic          last;

   always_comb begin
      unique case (stop_sel)
         STOP_HALF:     stop_len = HALF_T;
         STOP_ONE:      stop_len = BIT_T;
         STOP_ONE_HALF: stop_len = BIT_T + HALF_T;
         default:       stop_len = BIT_T + BIT_T;
      endcase
   end

   always_comb begin
      unique case (phase)
         PH_STOP:  len = stop_len;
         PH_BREAK: len = BRK_T;
         default:  len = BIT_T;
      endcase
   end

   assign last  = tick && (tcnt == len - TW'(1));
   assign shift = (phase == PH_DATA) && last;
   assign busy  = (phase != PH_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         tcnt  <= '0;
         bidx  <= '0;
      end else if (phase == PH_IDLE) begin
         tcnt <= '0;
         bidx <= '0;
         if (start_break)
            phase <= PH_BREAK;
         else if (start_data)
            phase <= PH_START;
      end else if (tick) begin
         if (last) begin
            tcnt <= '0;
            unique case (phase)
               PH_START: begin
                  phase <= PH_DATA;
                  bidx  <= '0;
               end
               PH_DATA: begin
                  if (bidx == LAST_IX)
                     phase <= PH_STOP;
                  else
                     bidx <= bidx + BW'(1);
               end
               PH_BREAK: phase <= PH_BRK_STOP;
               default:  phase <= PH_IDLE;
            endcase
         end else begin
            tcnt <= tcnt + TW'(1);
         end
      end
   end

endmodule

// File: rtl/sst_clk_gen.sv
module sst_clk_gen
   import sst_pkg::*;
#(
   parameter int OVS = 16,
   parameter int TW  = 8
) (
   input  phase_e        phase,
   input  logic [TW-1:0] tcnt,
   input  logic          busy,
   input  logic          clk_en_q,
   input  logic          cpol_q,
   input  logic          cpha_q,
   input  logic          cpol_live,
   output logic          clk_line
);

   localparam logic [TW-1:0] MID_T = TW'(OVS / 2);

   logic second_half;
   logic active;

   assign second_half = (tcnt >= MID_T);
   assign active      = clk_en_q && (phase == PH_DATA) &&
                        (cpha_q ? !second_half : second_half);

   always_comb begin
      if (busy)
         clk_line = cpol_q ^ active;
      else
         clk_line = cpol_live;
   end

endmodule

// File: rtl/sync_serial_tx.sv
module sync_serial_tx
   import sst_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVS      = 16,
   parameter int BRK_BITS = 13,
   localparam int TW      = $clog2(BRK_BITS * OVS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic [1:0]        cfg_stop,
   input  logic              cfg_clk_en,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic              cfg_lin_en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              brk_req,
   output logic              tx_line,
   output logic              clk_line,
   output logic              busy
);

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("OVS must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end
   if (BRK_BITS < 2) begin : g_bad_brk
      $error("BRK_BITS must be at least 2");
   end

   frame_cfg_t    cfg_in;
   frame_cfg_t    cfg_q;
   phase_e        phase;
   logic [TW-1:0] tcnt;
   logic          shift;
   logic          bit_q;
   logic          brk_take;
   logic          data_take;

   assign brk_take  = brk_req && cfg_lin_en && !busy;
   assign in_ready  = !busy && !(brk_req && cfg_lin_en);
   assign data_take = in_valid && in_ready;

   assign cfg_in = '{stop: stop_e'(cfg_stop), clk_en: cfg_clk_en,
                     cpol: cfg_cpol, cpha: cfg_cpha};

   sst_frame_store #(.DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (data_take || brk_take),
      .shift   (shift),
      .cfg_in  (cfg_in),
      .data_in (in_data),
      .cfg_q   (cfg_q),
      .bit_q   (bit_q)
   );

   sst_sequencer #(.DATA_W(DATA_W), .OVS(OVS), .BRK_BITS(BRK_BITS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (baud_tick),
      .start_data  (data_take),
      .start_break (brk_take),
      .stop_sel    (cfg_q.stop),
      .phase       (phase),
      .tcnt        (tcnt),
      .shift       (shift),
      .busy        (busy)
   );

   sst_clk_gen #(.OVS(OVS), .TW(TW)) u_clk (
      .phase     (phase),
      .tcnt      (tcnt),
      .busy      (busy),
      .clk_en_q  (cfg_q.clk_en),
      .cpol_q    (cfg_q.cpol),
      .cpha_q    (cfg_q.cpha),
      .cpol_live (cfg_cpol),
      .clk_line  (clk_line)
   );

   always_comb begin
      unique case (phase)
         PH_START, PH_BREAK: tx_line = 1'b0;
         PH_DATA:            tx_line = bit_q;
         default:            tx_line = 1'b1;
      endcase
   end

endmodule

// File: rtl/sst_checker.sv
module sst_checker (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic cfg_cpol,
   input logic cfg_lin_en,
   input logic in_valid,
   input logic in_ready,
   input logic brk_req,
   input logic tx_line,
   input logic clk_line,
   input logic busy
);

   assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tx_line && (clk_line == cfg_cpol)));

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (busy && !tx_line));

   assert_break_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && cfg_lin_en && !busy) |=> (busy && !tx_line));

   assert_break_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && !cfg_lin_en && !in_valid && !busy) |=> !busy);

   assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> ($stable(tx_line) && busy));

   assert_no_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready);

endmodule

bind sync_serial_tx sst_checker u_sst_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .baud_tick  (baud_tick),
   .cfg_cpol   (cfg_cpol),
   .cfg_lin_en (cfg_lin_en),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .brk_req    (brk_req),
   .tx_line    (tx_line),
   .clk_line   (clk_line),
   .busy       (busy)
);

// File: tb/test_sync_serial_tx.sv
`timescale 1ns/1ps
module test_sync_serial_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b1;
   logic [1:0] cfg_stop = 2'b00;
   logic       cfg_clk_en = 1'b0;
   logic       cfg_cpol = 1'b1;
   logic       cfg_cpha = 1'b0;
   logic       cfg_lin_en = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready;
   logic       brk_req = 1'b0;
   logic       tx_line;
   logic       clk_line;
   logic       busy;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit tick_sparse = 1'b0;
   int tick_div = 0;

   always #2 clk = ~clk;

   sync_serial_tx i_sync_serial_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_stop(cfg_stop), .cfg_clk_en(cfg_clk_en), .cfg_cpol(cfg_cpol),
      .cfg_cpha(cfg_cpha), .cfg_lin_en(cfg_lin_en),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .brk_req(brk_req), .tx_line(tx_line), .clk_line(clk_line), .busy(busy)
   );

   always @(negedge clk) begin
      if (tick_sparse) begin
         tick_div = (tick_div == 2) ? 0 : tick_div + 1;
         baud_tick = (tick_div == 0);
      end else begin
         baud_tick = 1'b1;
      end
   end

   task automatic summary();
      $display("  %0d/%0d checks passed", checks - fails, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int stop_ticks(input logic [1:0] s);
      case (s)
         2'b00:   return 16;
         2'b01:   return 8;
         2'b11:   return 24;
         default: return 32;
      endcase
   endfunction

   // vector: {data[7:0], stop[1:0], clk_en, cpol, cpha}
   localparam logic [12:0] VEC [6] = '{
      {8'hA5, 2'b00, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'b01, 1'b1, 1'b0, 1'b0},
      {8'h81, 2'b10, 1'b1, 1'b0, 1'b1},
      {8'h5A, 2'b11, 1'b1, 1'b1, 1'b0},
      {8'hFF, 2'b00, 1'b1, 1'b1, 1'b1},
      {8'h00, 2'b01, 1'b0, 1'b1, 1'b1}
   };

   task automatic run_frame(input logic [7:0] d, input logic [1:0] st,
                            input bit en, input bit pol, input bit pha,
                            input bit scramble, input bit poke);
      int L = stop_ticks(st);
      int bad_tx = 0, bad_clk = 0, bad_busy = 0;
      int a_tx = 0, x_tx = 0, a_clk = 0, x_clk = 0, a_b = 0, x_b = 0;
      @(negedge clk);
      in_data = d; cfg_stop = st; cfg_clk_en = en; cfg_cpol = pol; cfg_cpha = pha;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k <= 144 + L; k++) begin
         logic e_tx, e_clk, e_busy;
         if (scramble && k == 5) begin
            cfg_stop = ~st; cfg_clk_en = ~en; cfg_cpha = ~pha;
         end
         if (poke) begin
            in_valid = (k >= 30 && k < 40);
            in_data  = 8'h00;
         end
         e_busy = (k < 144 + L);
         if (k < 16)       e_tx = 1'b0;
         else if (k < 144) e_tx = d[(k - 16) / 16];
         else              e_tx = 1'b1;
         e_clk = pol;
         if (en && k >= 16 && k < 144) begin
            int j = (k - 16) % 16;
            e_clk = pha ? ((j < 8) ? ~pol : pol) : ((j >= 8) ? ~pol : pol);
         end
         if (tx_line !== e_tx && bad_tx == 0) begin a_tx = tx_line; x_tx = e_tx; end
         if (tx_line !== e_tx) bad_tx++;
         if (clk_line !== e_clk && bad_clk == 0) begin a_clk = clk_line; x_clk = e_clk; end
         if (clk_line !== e_clk) bad_clk++;
         if ((busy !== e_busy || in_ready !== !e_busy) && bad_busy == 0) begin
            a_b = {busy, in_ready}; x_b = {e_busy, !e_busy};
         end
         if (busy !== e_busy || in_ready !== !e_busy) bad_busy++;
         @(negedge clk);
      end
      in_valid = 1'b0;
      cfg_stop = st; cfg_clk_en = en; cfg_cpha = pha;
      check(bad_tx == 0, scramble ? "R8" : "R2", "data line frame", a_tx, x_tx);
      check(bad_clk == 0, en ? "R5" : "R4", "clock line frame", a_clk, x_clk);
      check(bad_busy == 0, poke ? "R10" : "R3", "busy/ready span", a_b, x_b);
   endtask

   task automatic run_break(input bit with_data);
      int bad_tx = 0, bad_b = 0;
      int a = 0, x = 0;
      @(negedge clk);
      cfg_lin_en = 1'b1; brk_req = 1'b1;
      in_valid = with_data; in_data = 8'hFF;
      @(posedge clk);
      @(negedge clk);
      brk_req = 1'b0; in_valid = 1'b0;
      for (int k = 0; k <= 224; k++) begin
         logic e_tx;
         e_tx = (k >= 208);
         if (tx_line !== e_tx && bad_tx == 0) begin a = tx_line; x = e_tx; end
         if (tx_line !== e_tx) bad_tx++;
         if (busy !== (k < 224)) bad_b++;
         @(negedge clk);
      end
      check(bad_tx == 0, "R6", "break low span", a, x);
      check(bad_b == 0, "R6", "break busy span", bad_b, 0);
   endtask

   initial begin
      int cnt;
      int bad;
      // R1: reset state with polarity high
      repeat (3) @(negedge clk);
      check(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1 && clk_line === 1'b1,
            "R1", "reset levels cpol=1", {tx_line, busy, in_ready, clk_line}, 4'b1011);
      rst_n = 1'b1;
      cfg_cpol = 1'b0;
      @(negedge clk);
      check(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1 && clk_line === 1'b0,
            "R1", "idle levels cpol=0", {tx_line, busy, in_ready, clk_line}, 4'b1010);

      // R2 R3 R4 R5: vector table
      for (int v = 0; v < 6; v++) begin
         logic [12:0] w = VEC[v];
         run_frame(w[12:5], w[4:3], w[2], w[1], w[0], 1'b0, 1'b0);
      end

      // R8: configuration changed mid-frame
      run_frame(8'hC3, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);

      // R10: byte offered while busy is not taken
      run_frame(8'h96, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      bad = 0;
      for (int k = 0; k < 20; k++) begin
         if (busy !== 1'b0 || tx_line !== 1'b1) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R10", "no frame from byte offered while busy", bad, 0);

      // R6: break, alone and with a competing byte
      run_break(1'b0);
      run_break(1'b1);

      // R7: break ignored with break mode off
      cfg_lin_en = 1'b0;
      brk_req = 1'b1;
      bad = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (busy !== 1'b0 || tx_line !== 1'b1) bad++;
      end
      brk_req = 1'b0;
      check(bad == 0, "R7", "break ignored", bad, 0);

      // R9: sparse ticks, one every third cycle, half stop bit
      tick_sparse = 1'b1;
      cfg_stop = 2'b01;
      cfg_clk_en = 1'b0;
      repeat (4) @(negedge clk);
      in_data = 8'h55;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      cnt = 0;
      while (busy === 1'b1 && cnt < 2000) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt >= 454 && cnt <= 456, "R9", "busy cycles with sparse ticks", cnt, 455);
      tick_sparse = 1'b0;

      summary();
      $finish;
   end

endmodule